// File: doc/BRIEF.md
# Stored-Sample Minimum, Maximum and Mean Unit

The unit keeps a small internal table of 32 unsigned words, each `DATA_W` bits wide. A host fills the table through a synchronous write port, one word per clock. It then raises a go request. The unit makes a single pass over all 32 entries and tracks three results as it goes: the smallest value, the largest value and a running total. The mean is taken from the total by a right shift of five bits.

When the pass finishes, the unit raises a ready flag. It keeps that flag high for as long as the go request stays high. While ready is high, the host picks one result at a time with a 2-bit select code and reads it on the output data bus. Dropping go returns the unit to idle, and the results stay readable there until the next pass. Loading, computing and reading are separate phases. Writing the table during a pass is not supported, and neither is reading results during a pass.

Top module: `stat_scan_engine`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, `wr_data` is stored in the table entry chosen by the 5-bit `wr_addr`. A later pass uses the stored values, and the most recent write to an entry replaces the earlier one.
- R2: A synchronous active-high `rst` clears every table entry, every result register, the scan index and `ready`. After reset, `ready` reads 0. A pass started straight after reset returns 0 for the minimum, the maximum and the mean.
- R3: After a pass, the minimum result equals the smallest unsigned value among the 32 entries.
- R4: After a pass, the maximum result equals the largest unsigned value among the 32 entries.
- R5: After a pass, the mean result equals floor(sum of the 32 entries / 32). The total is kept in `DATA_W`+5 bits, so it never overflows; with all entries at the largest value, the mean is that largest value.
- R6: `rd_sel` picks the value on `rd_data`: 2'b00 gives zero, 2'b01 gives the minimum, 2'b10 gives the maximum and 2'b11 gives the mean. The choice is combinational.
- R7: Suppose `go` is high at the rising edge where the unit is idle. Then `ready` becomes high right after the 33rd rising edge that follows that edge. It stays high, with the results unchanged, while `go` stays high.
- R8: A rising edge with `ready` high and `go` low drops `ready` in that same edge and returns the unit to idle. The results stay readable until a new pass starts.
- R9: Each new pass starts from a minimum of all ones, a maximum of zero and a total of zero. Results from an earlier pass therefore have no effect on the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | DATA_W | Word to store in the table |
| wr_addr | input | 5 | Table entry to write |
| wr_en | input | 1 | Write strobe |
| go | input | 1 | Requests a pass; hold high until results are read |
| ready | output | 1 | Results of the last pass are valid |
| rd_sel | input | 2 | Result select code |
| rd_data | output | DATA_W | Selected result |

## Verification
The checker assumes the host never writes the table while a pass is running. It also assumes that `go` stays high from the moment it is accepted until `ready` rises. Only on those terms do the properties hold: results stable while ready, and the mean lying between the minimum and the maximum. The bench keeps within these terms. It loads the table only while idle, holds `go` high through each pass, and drops it only after reading every result. The random data is drawn from several value ranges, including narrow ranges and full-scale words, alongside directed patterns for the extreme values.

// File: rtl/sse_pkg.sv
package sse_pkg;

    localparam int unsigned ENTRIES  = 32;
    localparam int unsigned ADDR_W   = $clog2(ENTRIES);
    localparam int unsigned IDX_W    = ADDR_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } sse_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_MIN  = 2'b01,
        SEL_MAX  = 2'b10,
        SEL_AVG  = 2'b11
    } sse_sel_e;

    function automatic logic idx_in_range(input logic [IDX_W-1:0] idx);
        return idx < IDX_W'(ENTRIES);
    endfunction

endpackage

// File: rtl/sse_store.sv
module sse_store
    import sse_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] table_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[e] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(e))) begin
                table_q[e] <= wr_data;
            end
        end
    end

    assign rd_word = table_q[rd_addr];

endmodule

// File: rtl/sse_accum.sv
module sse_accum
    import sse_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] res_min,
    output logic [DATA_W-1:0] res_max,
    output logic [DATA_W-1:0] res_avg
);

    localparam int unsigned SUM_W = DATA_W + ADDR_W;

    logic [DATA_W-1:0] min_q, max_q;
    logic [SUM_W-1:0]  sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            min_q <= '0;
            max_q <= '0;
            sum_q <= '0;
        end else if (clr) begin
            min_q <= '1;
            max_q <= '0;
            sum_q <= '0;
        end else if (step) begin
            sum_q <= sum_q + SUM_W'(sample);
            if (sample < min_q) min_q <= sample;
            if (sample > max_q) max_q <= sample;
        end
    end

    assign res_min = min_q;
    assign res_max = max_q;
    assign res_avg = sum_q[SUM_W-1:ADDR_W];

endmodule

// File: rtl/sse_ctrl.sv
module sse_ctrl
    import sse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              clr,
    output logic              step,
    output logic [ADDR_W-1:0] scan_addr,
    output logic              ready
);

    sse_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             ready_q;

    always_comb begin
        clr  = (state_q == ST_IDLE) && go;
        step = (state_q == ST_SCAN) && idx_in_range(idx_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (idx_in_range(idx_q)) begin
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        ready_q <= 1'b1;
                        state_q <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!go) begin
                        ready_q <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign scan_addr = idx_q[ADDR_W-1:0];
    assign ready     = ready_q;

endmodule

// File: rtl/stat_scan_engine.sv
module stat_scan_engine
    import sse_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [4:0]        wr_addr,
    input  logic              wr_en,
    input  logic              go,
    output logic              ready,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic              clr, step;
    logic [ADDR_W-1:0] scan_addr;
    logic [DATA_W-1:0] sample;
    logic [DATA_W-1:0] res_min, res_max, res_avg;

    sse_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (scan_addr),
        .rd_word (sample)
    );

    sse_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .clr       (clr),
        .step      (step),
        .scan_addr (scan_addr),
        .ready     (ready)
    );

    sse_accum #(.DATA_W(DATA_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step    (step),
        .sample  (sample),
        .res_min (res_min),
        .res_max (res_max),
        .res_avg (res_avg)
    );

    always_comb begin
        unique case (sse_sel_e'(rd_sel))
            SEL_MIN: rd_data = res_min;
            SEL_MAX: rd_data = res_max;
            SEL_AVG: rd_data = res_avg;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/sse_checker.sv
module sse_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              go,
    input logic              ready,
    input logic [1:0]        rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] res_min,
    input logic [DATA_W-1:0] res_max,
    input logic [DATA_W-1:0] res_avg
);

    // R3 / R4: a finished pass never reports min above max
    p_order_r3: assert property (@(posedge clk) disable iff (rst)
        ready |-> (res_min <= res_max));

    // R5: the mean lies between the extremes
    p_mean_range_r5: assert property (@(posedge clk) disable iff (rst)
        ready |-> ((res_avg >= res_min) && (res_avg <= res_max)));

    // R6: code 00 reads zero
    p_sel_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'b00) |-> (rd_data == '0));

    // R7: ready holds while go stays high
    p_ready_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (ready && go) |=> ready);

    // R7: results frozen while ready and go stay high
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (ready && go) |=> ($stable(res_min) && $stable(res_max) && $stable(res_avg)));

    // R8: dropping go clears ready
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && !go) |=> !ready);

endmodule

bind stat_scan_engine sse_checker #(.DATA_W(DATA_W)) u_sse_checker (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .ready   (ready),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .res_min (res_min),
    .res_max (res_max),
    .res_avg (res_avg)
);

// File: tb/test_stat_scan_engine.sv
module test_stat_scan_engine;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] wr_data;
    logic [4:0]   wr_addr;
    logic         wr_en;
    logic         go;
    logic         ready;
    logic [1:0]   rd_sel;
    logic [W-1:0] rd_data;

    int unsigned  n_tests = 0;
    int unsigned  n_fail  = 0;
    logic [W-1:0] model [32];

    always #10 clk = ~clk;

    stat_scan_engine #(.DATA_W(W)) i_stat_scan_engine (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_addr(wr_addr),
        .wr_en(wr_en), .go(go), .ready(ready), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [W-1:0] ref_min();
        logic [W-1:0] m = '1;
        for (int k = 0; k < 32; k++) if (model[k] < m) m = model[k];
        return m;
    endfunction

    function automatic logic [W-1:0] ref_max();
        logic [W-1:0] m = '0;
        for (int k = 0; k < 32; k++) if (model[k] > m) m = model[k];
        return m;
    endfunction

    function automatic logic [W-1:0] ref_avg();
        int unsigned s = 0;
        for (int k = 0; k < 32; k++) s += model[k];
        return W'(s / 32);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        model[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_sel(input logic [1:0] s, output logic [W-1:0] v);
        rd_sel = s;
        #2;
        v = rd_data;
    endtask

    // start a pass, return rising edges between capture edge and ready
    task automatic run_pass(output int lat);
        @(negedge clk);
        go = 1'b1;
        @(posedge clk);
        lat = 0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (ready || lat > 100) break;
        end
    endtask

    task automatic check_results(input string tag);
        logic [W-1:0] v;
        read_sel(2'b01, v); check({tag, " R3 min"}, int'(v), int'(ref_min()));
        read_sel(2'b10, v); check({tag, " R4 max"}, int'(v), int'(ref_max()));
        read_sel(2'b11, v); check({tag, " R5 avg"}, int'(v), int'(ref_avg()));
        read_sel(2'b00, v); check({tag, " R6 sel00"}, int'(v), 0);
    endtask

    task automatic end_pass();
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        check("R8 ready drop", int'(ready), 0);
    endtask

    initial begin
        #3000000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lat;
        logic [W-1:0] v;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; go = 0; rd_sel = 0;
        for (int k = 0; k < 32; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 ready after reset", int'(ready), 0);
        read_sel(2'b01, v); check("R2 min after reset", int'(v), 0);

        // R2: pass over a cleared table
        run_pass(lat);
        check("R7 latency", lat, 33);
        check_results("R2 cleared table");
        // R7: hold go high, results and ready stay
        repeat (5) @(negedge clk);
        check("R7 ready held", int'(ready), 1);
        check_results("R7 held");
        end_pass();
        // R8: results remain readable in idle
        check_results("R8 idle readback");

        // R1 / R3 / R4: directed extremes at first and last entries
        for (int k = 0; k < 32; k++) put(k, W'(100));
        put(0, W'(3));
        put(31, W'(250));
        put(31, W'(251));   // R1 overwrite
        run_pass(lat);
        check("R7 latency directed", lat, 33);
        check_results("R1 directed");
        end_pass();

        // R5: full-scale total, no overflow
        for (int k = 0; k < 32; k++) put(k, '1);
        run_pass(lat);
        check_results("R5 full scale");
        end_pass();

        // R9: previous results (min=max=255) must not leak
        for (int k = 0; k < 32; k++) put(k, W'(k + 10));
        run_pass(lat);
        check_results("R9 fresh pass");
        end_pass();

        // random passes over several ranges
        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 32; k++) begin
                case (p % 4)
                    0: put(k, W'($urandom));
                    1: put(k, W'(200 + $urandom_range(0, 55)));
                    2: put(k, W'($urandom_range(0, 7)));
                    default: put(k, W'($urandom_range(60, 70)));
                endcase
            end
            run_pass(lat);
            check("R7 latency random", lat, 33);
            check_results("R3 R4 R5 random");
            end_pass();
        end

        // R2: mid-use reset clears table and results
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 32; k++) model[k] = '0;
        @(negedge clk);
        check("R2 ready after second reset", int'(ready), 0);
        read_sel(2'b10, v); check("R2 max after second reset", int'(v), 0);
        run_pass(lat);
        check_results("R2 table cleared");
        end_pass();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule